// File: doc/BRIEF.md
# Stream Table Entry Locator

This block maps a device stream identifier to the byte address of the 64-byte configuration entry that describes that stream. The entry lives in a table in memory. The table is either one flat array indexed by the stream identifier, or a two-level structure. In the two-level structure, a directory of 8-byte descriptors points to smaller second-level arrays. The table base, a format selector and a split position come from configuration inputs. The block samples them at the moment it accepts a request.

Requests enter through a valid/ready port that carries the stream identifier. In two-level mode the block issues one 8-byte read on a valid/ready memory request channel. It then takes the descriptor from a response strobe that carries the data and an error flag. Only then does it produce a single result on a valid/ready output. The result holds either the entry address or a fault code with its associated address. The block handles one request at a time. It raises `req_ready` only when idle, and it holds the result stable for as long as the consumer keeps `res_ready` low.

Top module: `stw_walker`

## Requirements
- R1: A stream identifier of 2^SID_BITS (4096) or more returns fault code 1 with address 0 and issues no memory read. This applies in both table formats.
- R2: The two-level format is used when `cfg_fmt` equals 1, and the flat format for any other value. The base, format and split are sampled when the request is accepted, and changing them later has no effect on that request's result.
- R3: In the flat format the result is fault code 0 with address (base with bits [5:0] cleared) + sid*64, and no memory read is issued.
- R4: In the two-level format the block issues exactly one read at address (base with bits [5:0] cleared) + (sid >> split)*8.
- R5: If the read response carries the error flag, the result is fault code 2 and the address of the first-level descriptor.
- R6: A descriptor whose span field (bits [4:0]) is zero returns fault code 1 with address 0.
- R7: The second-level index is sid mod 2^split. An index greater than 2^span - 1 returns fault code 3 with address 0.
- R8: Otherwise the result is fault code 0 with address (descriptor bits [51:6] * 64) + index*64.
- R9: Once asserted, `res_valid` stays high with stable fault and address until `res_ready` is sampled high. Each accepted request produces exactly one result, and `req_ready` is low while a request is in flight.
- R10: Once asserted, `mem_req_valid` stays high with a stable, 8-byte aligned address until `mem_req_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_sid | input | SID_W | Stream identifier |
| cfg_base | input | ADDR_W | Table base address |
| cfg_fmt | input | 2 | Table format selector (1 = two-level) |
| cfg_split | input | SPLIT_W | Bit position at which the identifier is split |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Descriptor contents |
| mem_rsp_err | input | 1 | Read ended in a bus error |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 2 | 0 ok, 1 bad stream, 2 fetch error, 3 bad entry |
| res_addr | output | ADDR_W | Entry address, or faulting descriptor address |

## Verification
The assertions assume three things about the environment. The memory side returns exactly one response for each accepted read, and never returns one when no read is outstanding. Requesters keep `req_valid` and `req_sid` steady until accepted. The consumer may stall `res_ready` for any length of time. The bench memory model follows these rules: it answers each accepted read once, after a random delay of zero to two cycles, and it toggles its ready signal at random. The bench result consumer also inserts random stalls, so the hold properties on both output channels are exercised.

// File: rtl/stw_pkg.sv
package stw_pkg;
  typedef enum logic [1:0] {
    STW_OK        = 2'd0,
    STW_BAD_SID   = 2'd1,
    STW_FETCH     = 2'd2,
    STW_BAD_ENTRY = 2'd3
  } stw_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_DONE
  } stw_state_e;
endpackage

// File: rtl/stw_index.sv
module stw_index #(
  parameter int SID_W    = 16,
  parameter int SID_BITS = 12,
  parameter int ADDR_W   = 52,
  parameter int SPLIT_W  = 5,
  parameter int ENTRY_LG = 6,
  parameter int DESC_LG  = 3
) (
  input  logic [SID_W-1:0]   sid,
  input  logic [SPLIT_W-1:0] split,
  input  logic [ADDR_W-1:0]  base,
  output logic               sid_oor,
  output logic [ADDR_W-1:0]  l1_addr,
  output logic [SID_W-1:0]   l2_idx,
  output logic [ADDR_W-1:0]  lin_addr
);
  logic [ADDR_W-1:0] base_al;
  logic [SID_W-1:0]  l1_idx;

  assign base_al = {base[ADDR_W-1:ENTRY_LG], {ENTRY_LG{1'b0}}};
  assign l1_idx  = sid >> split;
  assign l2_idx  = sid & ~({SID_W{1'b1}} << split);
  assign l1_addr  = base_al + (ADDR_W'(l1_idx) << DESC_LG);
  assign lin_addr = base_al + (ADDR_W'(sid) << ENTRY_LG);

  generate
    if (SID_BITS >= SID_W) begin : g_full_range
      assign sid_oor = 1'b0;
    end else begin : g_limited_range
      assign sid_oor = (sid >> SID_BITS) != '0;
    end
  endgenerate
endmodule

// File: rtl/stw_desc_check.sv
module stw_desc_check
  import stw_pkg::*;
#(
  parameter int SID_W    = 16,
  parameter int ADDR_W   = 52,
  parameter int ENTRY_LG = 6,
  parameter int SPAN_W   = 5,
  parameter int PTR_LO   = 6,
  parameter int PTR_HI   = 51
) (
  input  logic [63:0]       desc,
  input  logic              bus_err,
  input  logic [SID_W-1:0]  l2_idx,
  input  logic [ADDR_W-1:0] l1_addr,
  output stw_fault_e        fault,
  output logic [ADDR_W-1:0] addr
);
  logic [SPAN_W-1:0] span;
  logic [63:0]       ptr64;
  logic              over;
  logic [ADDR_W-1:0] entry;

  assign span  = desc[SPAN_W-1:0];
  assign ptr64 = 64'(desc[PTR_HI:PTR_LO]) << PTR_LO;
  assign over  = (l2_idx >> span) != '0;
  assign entry = ptr64[ADDR_W-1:0] + (ADDR_W'(l2_idx) << ENTRY_LG);

  always_comb begin
    fault = STW_OK;
    addr  = entry;
    if (bus_err) begin
      fault = STW_FETCH;
      addr  = l1_addr;
    end else if (span == '0) begin
      fault = STW_BAD_SID;
      addr  = '0;
    end else if (over) begin
      fault = STW_BAD_ENTRY;
      addr  = '0;
    end
  end
endmodule

// File: rtl/stw_walker.sv
module stw_walker
  import stw_pkg::*;
#(
  parameter int SID_W    = 16,
  parameter int SID_BITS = 12,
  parameter int ADDR_W   = 52,
  parameter int SPLIT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SID_W-1:0]   req_sid,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [1:0]         cfg_fmt,
  input  logic [SPLIT_W-1:0] cfg_split,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [1:0]         res_fault,
  output logic [ADDR_W-1:0]  res_addr
);
  localparam int ENTRY_LG = 6;
  localparam int DESC_LG  = 3;

  stw_state_e        state_q;
  logic [ADDR_W-1:0] l1_addr_q;
  logic [SID_W-1:0]  l2_idx_q;
  stw_fault_e        fault_q;
  logic [ADDR_W-1:0] addr_q;

  logic              sid_oor;
  logic [ADDR_W-1:0] l1_addr_c;
  logic [SID_W-1:0]  l2_idx_c;
  logic [ADDR_W-1:0] lin_addr_c;
  stw_fault_e        chk_fault;
  logic [ADDR_W-1:0] chk_addr;
  logic              accept;

  stw_index #(
    .SID_W(SID_W), .SID_BITS(SID_BITS), .ADDR_W(ADDR_W),
    .SPLIT_W(SPLIT_W), .ENTRY_LG(ENTRY_LG), .DESC_LG(DESC_LG)
  ) u_index (
    .sid(req_sid), .split(cfg_split), .base(cfg_base),
    .sid_oor(sid_oor), .l1_addr(l1_addr_c), .l2_idx(l2_idx_c),
    .lin_addr(lin_addr_c)
  );

  stw_desc_check #(
    .SID_W(SID_W), .ADDR_W(ADDR_W), .ENTRY_LG(ENTRY_LG)
  ) u_check (
    .desc(mem_rsp_data), .bus_err(mem_rsp_err), .l2_idx(l2_idx_q),
    .l1_addr(l1_addr_q), .fault(chk_fault), .addr(chk_addr)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign mem_req_valid = (state_q == ST_RD_REQ);
  assign mem_req_addr  = l1_addr_q;
  assign res_valid     = (state_q == ST_DONE);
  assign res_fault     = fault_q;
  assign res_addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      l1_addr_q <= '0;
      l2_idx_q  <= '0;
      fault_q   <= STW_OK;
      addr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (sid_oor) begin
            fault_q <= STW_BAD_SID;
            addr_q  <= '0;
            state_q <= ST_DONE;
          end else if (cfg_fmt == 2'd1) begin
            l1_addr_q <= l1_addr_c;
            l2_idx_q  <= l2_idx_c;
            state_q   <= ST_RD_REQ;
          end else begin
            fault_q <= STW_OK;
            addr_q  <= lin_addr_c;
            state_q <= ST_DONE;
          end
        end
        ST_RD_REQ: if (mem_req_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          fault_q <= chk_fault;
          addr_q  <= chk_addr;
          state_q <= ST_DONE;
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: result held until taken
  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_fault) && $stable(res_addr));
  // R9: no new request accepted while one is in flight
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid);
  // R10: memory request held until taken
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R4: descriptor reads are 8-byte aligned
  a_r4_desc_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[DESC_LG-1:0] == '0);
  // R8: successful results are entry aligned
  a_r8_entry_align: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 |-> res_addr[ENTRY_LG-1:0] == '0);
  // R1: out-of-range identifier never reaches memory
  a_r1_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    accept && sid_oor |=> res_valid && res_fault == 2'd1);
endmodule

// File: tb/stw_walker_tb.sv
module stw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sid = '0;
  logic [51:0] cfg_base = '0;
  logic [1:0]  cfg_fmt = '0;
  logic [4:0]  cfg_split = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_fault;
  logic [51:0] res_addr;

  int total = 0;
  int bad = 0;
  int reads = 0;
  logic        force_en = 1'b0;
  logic [63:0] force_desc = '0;
  logic        force_err = 1'b0;

  always #4 clk = ~clk;

  stw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sid(req_sid), .cfg_base(cfg_base), .cfg_fmt(cfg_fmt),
    .cfg_split(cfg_split), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .res_valid(res_valid), .res_ready(res_ready),
    .res_fault(res_fault), .res_addr(res_addr)
  );

  function automatic logic [63:0] hash(input logic [51:0] a);
    logic [63:0] h;
    h = (64'(a) * 64'h9E3779B97F4A7C15) ^ (64'(a) >> 7);
    return h;
  endfunction

  function automatic logic [63:0] desc_of(input logic [51:0] a);
    logic [63:0] h;
    if (force_en) return force_desc;
    h = hash(a);
    h[4:0] = 5'(h[44:41] % 10);
    return h;
  endfunction

  function automatic logic err_of(input logic [51:0] a);
    logic [63:0] h;
    if (force_en) return force_err;
    h = hash(a);
    return h[50:48] == 3'd0;
  endfunction

  function automatic void model(input logic [15:0] sid, input logic [1:0] fmt,
                                input logic [4:0] split, input logic [51:0] base,
                                output logic [1:0] f, output logic [51:0] a,
                                output int nrd, output string tag);
    logic [51:0] mb, l1;
    logic [63:0] d, l2;
    mb = base & ~52'h3f;
    nrd = 0;
    if (sid >= 16'd4096) begin
      f = 2'd1; a = '0; tag = "R1";
    end else if (fmt != 2'd1) begin
      f = 2'd0; a = mb + 52'(sid) * 52'd64; tag = "R3";
    end else begin
      nrd = 1;
      l1 = mb + (52'(sid) >> split) * 52'd8;
      d  = desc_of(l1);
      l2 = 64'(sid) & ((64'd1 << split) - 64'd1);
      if (err_of(l1)) begin
        f = 2'd2; a = l1; tag = "R5";
      end else if (d[4:0] == 5'd0) begin
        f = 2'd1; a = '0; tag = "R6";
      end else if (l2 > (64'd1 << d[4:0]) - 64'd1) begin
        f = 2'd3; a = '0; tag = "R7";
      end else begin
        f = 2'd0; a = 52'({d[51:6], 6'b0}) + 52'(l2) * 52'd64; tag = "R8";
      end
    end
  endfunction

  // memory responder: one response per accepted read
  initial begin
    logic        pend = 1'b0;
    int          dly = 0;
    logic [51:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = desc_of(pa);
          mem_rsp_err   = err_of(pa);
          pend = 1'b0;
        end else dly--;
      end
      mem_req_ready = !pend && ($urandom % 2 == 0);
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1; pa = mem_req_addr; dly = int'($urandom % 3); reads++;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [15:0] sid, input logic [1:0] fmt,
                      input logic [4:0] split, input logic [51:0] base,
                      input bit scramble, input int stall);
    logic [1:0]  ef;
    logic [51:0] ea;
    int          nrd, r0;
    string       tag;
    model(sid, fmt, split, base, ef, ea, nrd, tag);
    @(negedge clk);
    req_sid = sid; cfg_fmt = fmt; cfg_split = split; cfg_base = base;
    req_valid = 1'b1;
    r0 = reads;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_fmt = ~fmt; cfg_split = split + 5'd3; cfg_base = ~base;
    end
    while (!res_valid) @(negedge clk);
    repeat (stall) begin
      @(negedge clk);
      check({tag, " R9 hold"}, {62'd0, res_valid}, 64'd1);
    end
    check({tag, scramble ? " R2 fault" : " fault"}, 64'(res_fault), 64'(ef));
    check({tag, scramble ? " R2 addr" : " addr"}, 64'(res_addr), 64'(ea));
    check({tag, (nrd != 0) ? " R4 reads" : " R1/R3 no read"}, 64'(reads - r0), 64'(nrd));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R9 single result", {62'd0, res_valid}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset ready", {63'd0, req_ready}, 64'd1);
    check("R9 reset res_valid", {63'd0, res_valid}, 64'd0);
    check("R10 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);

    // directed corners
    walk(16'd0,    2'd0, 5'd4, 52'h1_2345_6789_AB, 0, 0);   // R3 low end, misaligned base
    walk(16'd4095, 2'd2, 5'd4, 52'h40_0000, 0, 2);          // R3 top id, fmt 2 is flat
    walk(16'd4096, 2'd1, 5'd4, 52'h40_0000, 0, 0);          // R1 two-level
    walk(16'hFFFF, 2'd0, 5'd4, 52'h40_0000, 0, 0);          // R1 flat
    force_en = 1'b1;
    force_desc = 64'h0000_0ABC_DE00_0003; force_err = 1'b1;
    walk(16'h0123, 2'd1, 5'd4, 52'h8000_0010, 0, 0);        // R5
    force_desc = 64'h0000_0ABC_DE00_0040; force_err = 1'b0;
    walk(16'h0123, 2'd1, 5'd4, 52'h8000_0000, 0, 0);        // R6 span 0
    force_desc = 64'h0000_0ABC_DE00_0002;
    walk(16'h0124, 2'd1, 5'd4, 52'h8000_0000, 0, 1);        // R7 idx 4 > 3
    walk(16'h0123, 2'd1, 5'd4, 52'h8000_0000, 0, 0);        // R8 idx 3 == max
    force_desc = 64'hFFF0_0ABC_DE00_0045;
    walk(16'h0FFF, 2'd1, 5'd0, 52'h8000_0000, 0, 0);        // R8 split 0
    walk(16'h0FFF, 2'd1, 5'd20, 52'h8000_0000, 0, 0);       // R7 split above width
    walk(16'h0055, 2'd1, 5'd3, 52'h8000_0000, 1, 3);        // R2 config change mid-walk
    force_en = 1'b0;
    walk(16'h0321, 2'd0, 5'd6, 52'h7_0000_1000, 1, 0);      // R2 flat config change

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] s;
      logic [1:0]  fm;
      s  = ($urandom % 16 == 0) ? 16'($urandom) : 16'($urandom % 4096);
      fm = ($urandom % 4 == 0) ? 2'($urandom) : 2'd1;
      walk(s, fm, 5'($urandom % 14), {20'($urandom), 32'($urandom)},
           ($urandom % 8 == 0), int'($urandom % 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule